// File: doc/BRIEF.md
# Parallel Flash Read Responder

This block answers read accesses to a NOR-style parallel flash model. A separate command decoder tracks the write-command sequences and tells this block which mode the part is in. On each read strobe the responder returns one of four things. It can return bytes from the storage array, identification words, a busy-status byte whose bit 6 flips on every read, or a byte of a common flash query table whose geometry fields are computed from the block's parameters.

The storage array is a byte-wide memory inside the block. The decoder fills and modifies it through a simple byte write port. Reads can be 1, 2 or 4 bytes wide and are assembled in little- or big-endian order according to a configuration input. The device width parameter scales the byte address down to a register offset for identification and query reads. When the decoder presents a mode value it does not define, the read is served as an array read and a one-cycle indication asks the decoder to return to read mode.

Top module: `flash_read_resp`

## Requirements
- R1: After reset `rdData` is 0, `forceRead` is 0 and the status byte is 0x00.
- R2: Read data and `forceRead` are registered: they update on the clock edge that samples `rdEn`=1 and hold their value while `rdEn` is 0.
- R3: In array mode (`mode`=0) and erase-setup mode (`mode`=1) a read returns stored bytes. `rdSize` 0/1/2/3 reads 1/2/4/4 bytes starting at `rdAddr`. In little-endian order (`bigEndian`=0) the byte at `rdAddr` sits in bits 7:0 and the following bytes sit in successively higher lanes. Bits above the read width are 0.
- R4: With `bigEndian`=1 a multi-byte read places the byte at `rdAddr` in the most significant lane of the read width.
- R5: The register offset for identification and query reads is `rdAddr[7:0]`, shifted right by log2(DEV_BYTES). Address bits above bit 7 do not affect it.
- R6: In autoselect mode (`mode`=2), offset 0 returns ID0 and offset 1 returns ID1, both zero-extended to 32 bits. Offset 2 returns 0.
- R7: In autoselect mode, offset 0x0E returns ID2 and offset 0x0F returns ID3. When that word is configured as 0xFFFF, the read returns array data instead, as does a read at any other offset.
- R8: In program, chip-erase and sector-erase modes (`mode`=3, 4, 5) a read returns the status byte zero-extended, and bit 6 of the status inverts after each such read. `stLoad` writes `stValue` into the status byte, and a load takes precedence over the inversion.
- R9: In query mode (`mode`=6) a read returns one table byte, zero-extended:
  - 0x10..0x12 hold 0x51, 0x52, 0x59.
  - 0x13 holds 0x02 and 0x15 holds 0x31.
  - 0x1B holds 0x27, 0x1C holds 0x36, 0x1F holds 0x07 and 0x23 holds 0x01.
  - 0x21, 0x22, 0x25 and 0x26 hold 0x09, 0x0C, 0x0A and 0x0D.
  - 0x28 holds 0x02.
  - 0x31..0x35 hold 0x50, 0x52, 0x49, 0x31, 0x30.

  Every other offset, including 0x2A and all offsets from 0x52 upward, returns 0.
- R10: Query byte 0x27 holds log2 of the chip size in bytes and byte 0x2C holds 1. Bytes 0x2D/0x2E hold SECTOR_COUNT-1 (low byte first). Bytes 0x2F/0x30 hold SECTOR_BYTES/256 (low byte first).
- R11: A read with `mode`=7 is served as an array read and sets `forceRead` for that result only. Any other read clears it.
- R12: Multi-byte array reads wrap from the last byte of the chip back to byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | ADDR_W | Byte address of the read |
| rdSize | input | 2 | Read width code: 0=1, 1=2, 2/3=4 bytes |
| mode | input | 3 | Current mode from the command decoder |
| bigEndian | input | 1 | Byte order of multi-byte reads |
| stLoad | input | 1 | Load the status byte |
| stValue | input | 8 | Value loaded into the status byte |
| memWe | input | 1 | Storage byte write enable |
| memWaddr | input | ADDR_W | Storage byte write address |
| memWdata | input | 8 | Storage byte write data |
| rdData | output | 32 | Registered read data |
| forceRead | output | 1 | Unrecognised mode seen on the last read |

## Verification
The bench sweeps every chip address in every read width and both byte orders. A responder that reversed lane order or failed to wrap at the chip end would return wrong bytes at the top addresses.

Autoselect and query reads are swept over all addresses. This catches an offset that ignores the device-width shift or leaks upper address bits into it. It also exposes an extended ID slot that returns 0xFFFF instead of falling back to array data, and a query table that returns garbage past 0x51 or wrong geometry bytes.

Back-to-back status reads across the three busy modes expose a bit 6 that fails to flip or flips on non-status reads. The bench also reads with the undefined mode value, which catches an indication that sticks or never fires.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

  localparam logic [2:0] MODE_ARRAY       = 3'd0;
  localparam logic [2:0] MODE_ERASE_SETUP = 3'd1;
  localparam logic [2:0] MODE_AUTOSEL     = 3'd2;
  localparam logic [2:0] MODE_PROG        = 3'd3;
  localparam logic [2:0] MODE_CHIP_ERASE  = 3'd4;
  localparam logic [2:0] MODE_SECT_ERASE  = 3'd5;
  localparam logic [2:0] MODE_QUERY       = 3'd6;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_IDWORD = 2'd1,
    SRC_STATUS = 2'd2,
    SRC_QUERY  = 2'd3
  } srcSel_e;

  // Strobes from the control decode to the datapath.
  typedef struct packed {
    logic       capture;   // a read is being served this cycle
    srcSel_e    src;       // which source feeds the result
    logic [1:0] idSel;     // 0: ID0, 1: ID1, 2: zero, 3: extended word
    logic       extHigh;   // extended word select: 0 -> ID2, 1 -> ID3
    logic [7:0] offset;    // scaled register offset
    logic       toggle;    // flip status bit 6 after this read
    logic       badMode;   // mode value not defined
  } rdStrobe_t;

endpackage

// File: rtl/flash_rd_ctrl.sv
module flash_rd_ctrl
  import flash_rd_pkg::*;
#(
  parameter int          DEV_BYTES = 2,
  parameter logic [15:0] ID2       = 16'h2201,
  parameter logic [15:0] ID3       = 16'hFFFF
) (
  input  logic       rdEn,
  input  logic [7:0] addrLow,
  input  logic [2:0] mode,
  output rdStrobe_t  strobe
);

  localparam int OFF_SHIFT = (DEV_BYTES == 4) ? 2 : (DEV_BYTES == 2) ? 1 : 0;
  localparam logic [15:0] ALL_ONES = 16'hFFFF;

  logic [7:0] regOff;
  assign regOff = addrLow >> OFF_SHIFT;

  always_comb begin
    strobe         = '0;
    strobe.capture = rdEn;
    strobe.offset  = regOff;
    strobe.src     = SRC_ARRAY;
    case (mode)
      MODE_ARRAY, MODE_ERASE_SETUP: strobe.src = SRC_ARRAY;
      MODE_AUTOSEL: begin
        case (regOff)
          8'h00: begin strobe.src = SRC_IDWORD; strobe.idSel = 2'd0; end
          8'h01: begin strobe.src = SRC_IDWORD; strobe.idSel = 2'd1; end
          8'h02: begin strobe.src = SRC_IDWORD; strobe.idSel = 2'd2; end
          8'h0E: if (ID2 != ALL_ONES) begin
            strobe.src = SRC_IDWORD; strobe.idSel = 2'd3; strobe.extHigh = 1'b0;
          end
          8'h0F: if (ID3 != ALL_ONES) begin
            strobe.src = SRC_IDWORD; strobe.idSel = 2'd3; strobe.extHigh = 1'b1;
          end
          default: strobe.src = SRC_ARRAY;
        endcase
      end
      MODE_PROG, MODE_CHIP_ERASE, MODE_SECT_ERASE: begin
        strobe.src    = SRC_STATUS;
        strobe.toggle = 1'b1;
      end
      MODE_QUERY: strobe.src = SRC_QUERY;
      default: begin
        strobe.src     = SRC_ARRAY;
        strobe.badMode = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/flash_rd_dp.sv
module flash_rd_dp
  import flash_rd_pkg::*;
#(
  parameter int          SECTOR_BYTES = 256,
  parameter int          SECTOR_COUNT = 4,
  parameter logic [15:0] ID0          = 16'h0001,
  parameter logic [15:0] ID1          = 16'h227E,
  parameter logic [15:0] ID2          = 16'h2201,
  parameter logic [15:0] ID3          = 16'hFFFF,
  localparam int CHIP_BYTES = SECTOR_BYTES * SECTOR_COUNT,
  localparam int ADDR_W     = $clog2(CHIP_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobe_t         strobe,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [1:0]        rdSize,
  input  logic              bigEndian,
  input  logic              stLoad,
  input  logic [7:0]        stValue,
  input  logic              memWe,
  input  logic [ADDR_W-1:0] memWaddr,
  input  logic [7:0]        memWdata,
  output logic [31:0]       rdData,
  output logic              forceRead
);

  localparam int LANES = 4;
  localparam logic [7:0]  CHIP_LOG2 = 8'(ADDR_W);
  localparam logic [15:0] CNT_M1    = 16'(SECTOR_COUNT - 1);
  localparam logic [15:0] SZ_DIV    = 16'(SECTOR_BYTES / 256);

  logic [7:0] store [CHIP_BYTES];

  always_ff @(posedge clk) begin
    if (memWe) store[memWaddr] <= memWdata;
  end

  // Byte lanes, wrapping within the chip.
  logic [7:0] lane [LANES];
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = store[rdAddr + ADDR_W'(g)];
  end

  logic [31:0] arrWord;
  int          nBytes;
  always_comb begin
    arrWord = '0;
    nBytes  = (rdSize == 2'd0) ? 1 : (rdSize == 2'd1) ? 2 : 4;
    for (int i = 0; i < LANES; i++) begin
      if (i < nBytes) begin
        if (bigEndian) arrWord[8*(nBytes-1-i) +: 8] = lane[i];
        else           arrWord[8*i +: 8]            = lane[i];
      end
    end
  end

  function automatic logic [7:0] queryByte(input logic [7:0] off);
    case (off)
      8'h10: return 8'h51;
      8'h11: return 8'h52;
      8'h12: return 8'h59;
      8'h13: return 8'h02;
      8'h15: return 8'h31;
      8'h1B: return 8'h27;
      8'h1C: return 8'h36;
      8'h1F: return 8'h07;
      8'h21: return 8'h09;
      8'h22: return 8'h0C;
      8'h23: return 8'h01;
      8'h25: return 8'h0A;
      8'h26: return 8'h0D;
      8'h27: return CHIP_LOG2;
      8'h28: return 8'h02;
      8'h2C: return 8'h01;
      8'h2D: return CNT_M1[7:0];
      8'h2E: return CNT_M1[15:8];
      8'h2F: return SZ_DIV[7:0];
      8'h30: return SZ_DIV[15:8];
      8'h31: return 8'h50;
      8'h32: return 8'h52;
      8'h33: return 8'h49;
      8'h34: return 8'h31;
      8'h35: return 8'h30;
      default: return 8'h00;
    endcase
  endfunction

  logic [7:0] statusQ;

  always_ff @(posedge clk) begin
    if (!rstN)                                statusQ <= 8'h00;
    else if (stLoad)                          statusQ <= stValue;
    else if (strobe.capture && strobe.toggle) statusQ[6] <= ~statusQ[6];
  end

  logic [15:0] idWord;
  always_comb begin
    case (strobe.idSel)
      2'd0:    idWord = ID0;
      2'd1:    idWord = ID1;
      2'd2:    idWord = 16'h0000;
      default: idWord = strobe.extHigh ? ID3 : ID2;
    endcase
  end

  logic [31:0] nextData;
  always_comb begin
    case (strobe.src)
      SRC_IDWORD: nextData = {16'h0000, idWord};
      SRC_STATUS: nextData = {24'h0, statusQ};
      SRC_QUERY:  nextData = {24'h0, queryByte(strobe.offset)};
      default:    nextData = arrWord;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData    <= '0;
      forceRead <= 1'b0;
    end else if (strobe.capture) begin
      rdData    <= nextData;
      forceRead <= strobe.badMode;
    end
  end

endmodule

// File: rtl/flash_read_resp.sv
module flash_read_resp
  import flash_rd_pkg::*;
#(
  parameter int          DEV_BYTES    = 2,
  parameter int          SECTOR_BYTES = 256,
  parameter int          SECTOR_COUNT = 4,
  parameter logic [15:0] ID0          = 16'h0001,
  parameter logic [15:0] ID1          = 16'h227E,
  parameter logic [15:0] ID2          = 16'h2201,
  parameter logic [15:0] ID3          = 16'hFFFF,
  localparam int ADDR_W = $clog2(SECTOR_BYTES * SECTOR_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [1:0]        rdSize,
  input  logic [2:0]        mode,
  input  logic              bigEndian,
  input  logic              stLoad,
  input  logic [7:0]        stValue,
  input  logic              memWe,
  input  logic [ADDR_W-1:0] memWaddr,
  input  logic [7:0]        memWdata,
  output logic [31:0]       rdData,
  output logic              forceRead
);

  rdStrobe_t strobe;

  flash_rd_ctrl #(
    .DEV_BYTES(DEV_BYTES), .ID2(ID2), .ID3(ID3)
  ) u_ctrl (
    .rdEn(rdEn), .addrLow(rdAddr[7:0]), .mode(mode), .strobe(strobe)
  );

  flash_rd_dp #(
    .SECTOR_BYTES(SECTOR_BYTES), .SECTOR_COUNT(SECTOR_COUNT),
    .ID0(ID0), .ID1(ID1), .ID2(ID2), .ID3(ID3)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdAddr(rdAddr),
    .rdSize(rdSize), .bigEndian(bigEndian), .stLoad(stLoad),
    .stValue(stValue), .memWe(memWe), .memWaddr(memWaddr),
    .memWdata(memWdata), .rdData(rdData), .forceRead(forceRead)
  );

endmodule

// File: rtl/flash_rd_chk.sv
module flash_rd_chk
  import flash_rd_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        rdEn,
  input logic [1:0]  rdSize,
  input logic [2:0]  mode,
  input logic        stLoad,
  input logic [31:0] rdData,
  input logic        forceRead
);

  logic busyRd;
  assign busyRd = rdEn && !stLoad &&
                  (mode == MODE_PROG || mode == MODE_CHIP_ERASE || mode == MODE_SECT_ERASE);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData) && $stable(forceRead));

  p_narrow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdSize == 2'd0 && mode == MODE_ARRAY) |=> rdData[31:8] == 24'h0);

  p_toggle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busyRd && $past(busyRd)) |=> rdData[6] != $past(rdData[6]));

  p_query_byte_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && mode == MODE_QUERY) |=> rdData[31:8] == 24'h0);

  p_force_set_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && mode == 3'd7) |=> forceRead);

  p_force_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && mode != 3'd7) |=> !forceRead);

endmodule

bind flash_read_resp flash_rd_chk u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdSize(rdSize), .mode(mode),
  .stLoad(stLoad), .rdData(rdData), .forceRead(forceRead)
);

// File: tb/flash_read_resp_tb.sv
module flash_read_resp_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CHIP       = 1024;
  localparam int AW         = 10;
  localparam logic [15:0] T_ID0 = 16'h0001;
  localparam logic [15:0] T_ID1 = 16'h227E;
  localparam logic [15:0] T_ID2 = 16'h2201;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rdEn = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic [1:0]    rdSize = '0;
  logic [2:0]    mode = '0;
  logic          bigEndian = 1'b0;
  logic          stLoad = 1'b0;
  logic [7:0]    stValue = '0;
  logic          memWe = 1'b0;
  logic [AW-1:0] memWaddr = '0;
  logic [7:0]    memWdata = '0;
  logic [31:0]   rdData;
  logic          forceRead;

  int  nTests = 0;
  int  nFails = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_read_resp u_dut (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr), .rdSize(rdSize),
    .mode(mode), .bigEndian(bigEndian), .stLoad(stLoad), .stValue(stValue),
    .memWe(memWe), .memWaddr(memWaddr), .memWdata(memWdata),
    .rdData(rdData), .forceRead(forceRead)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a % CHIP) * 7 + 3 + (a % CHIP) / 256);
  endfunction

  function automatic logic [31:0] expArr(input int a, input int sz, input bit be);
    int n;
    logic [31:0] r;
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    r = '0;
    for (int i = 0; i < n; i++) begin
      if (be) r[8*(n-1-i) +: 8] = pat(a + i);
      else    r[8*i +: 8]       = pat(a + i);
    end
    return r;
  endfunction

  function automatic logic [7:0] expQuery(input int o);
    case (o)
      'h10: return 8'h51; 'h11: return 8'h52; 'h12: return 8'h59;
      'h13: return 8'h02; 'h15: return 8'h31; 'h1B: return 8'h27;
      'h1C: return 8'h36; 'h1F: return 8'h07; 'h21: return 8'h09;
      'h22: return 8'h0C; 'h23: return 8'h01; 'h25: return 8'h0A;
      'h26: return 8'h0D; 'h27: return 8'($clog2(CHIP));
      'h28: return 8'h02; 'h2C: return 8'h01;
      'h2D: return 8'(4 - 1); 'h2E: return 8'((4 - 1) >> 8);
      'h2F: return 8'(256 / 256); 'h30: return 8'((256 / 256) >> 8);
      'h31: return 8'h50; 'h32: return 8'h52; 'h33: return 8'h49;
      'h34: return 8'h31; 'h35: return 8'h30;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nTests++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic doRead(input int a, input int sz, input logic [2:0] m, input bit be,
                        output logic [31:0] d, output logic f);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = AW'(a); rdSize = 2'(sz); mode = m; bigEndian = be;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
    f = forceRead;
  endtask

  task automatic loadStatus(input logic [7:0] v);
    @(negedge clk);
    stLoad = 1'b1; stValue = v;
    @(negedge clk);
    stLoad = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, e, hold;
    logic        f;
    logic [7:0]  st;
    int          off;

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rdData", rdData, 32'h0);
    check("R1 forceRead", {31'h0, forceRead}, 32'h0);
    rstN = 1'b1;

    for (int a = 0; a < CHIP; a++) begin
      @(negedge clk);
      memWe = 1'b1; memWaddr = AW'(a); memWdata = pat(a);
    end
    @(negedge clk);
    memWe = 1'b0;

    // R1: status starts at zero
    doRead(0, 0, 3'd3, 1'b0, d, f);
    check("R1 status", d, 32'h0);
    loadStatus(8'h00);

    // R3/R4/R12: full array sweep, every width and order, both array modes
    for (int a = 0; a < CHIP; a++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int be = 0; be < 2; be++) begin
          doRead(a, sz, 3'(a % 2), be[0], d, f);
          e = expArr(a, (sz == 3) ? 2 : sz, be[0]);
          if (a >= CHIP - 3) check("R12 wrap", d, e);
          else if (be != 0)  check("R4 big endian", d, e);
          else               check("R3 array", d, e);
        end
      end
    end

    // R2: hold while idle
    hold = rdData;
    repeat (5) @(negedge clk);
    check("R2 hold", rdData, hold);

    // R5/R6/R7: autoselect sweep over all addresses
    for (int a = 0; a < CHIP; a++) begin
      doRead(a, 1, 3'd2, 1'b0, d, f);
      off = (a % 256) >> 1;
      case (off)
        0:    e = {16'h0, T_ID0};
        1:    e = {16'h0, T_ID1};
        2:    e = 32'h0;
        'h0E: e = {16'h0, T_ID2};
        default: e = expArr(a, 1, 1'b0);
      endcase
      if (off <= 2) check("R6 id", d, e);
      else if (off == 'h0E || off == 'h0F) check("R7 ext id", d, e);
      else check("R5 fallback", d, e);
    end

    // R9/R10/R5: query sweep over all addresses
    for (int a = 0; a < CHIP; a++) begin
      doRead(a, 2, 3'd6, a[0], d, f);
      off = (a % 256) >> 1;
      e = {24'h0, expQuery(off)};
      if (off >= 'h27 && off <= 'h30) check("R10 geometry", d, e);
      else check("R9 query", d, e);
    end

    // R8: status toggling across the busy modes, load precedence
    loadStatus(8'h80);
    st = 8'h80;
    for (int k = 0; k < 6; k++) begin
      doRead(k * 5, 2, 3'(3 + (k % 3)), 1'b0, d, f);
      check("R8 status", d, {24'h0, st});
      st[6] = ~st[6];
    end
    doRead(0, 2, 3'd0, 1'b0, d, f);
    doRead(0, 2, 3'd3, 1'b0, d, f);
    check("R8 no toggle on array read", d, {24'h0, st});
    loadStatus(8'h25);
    doRead(0, 0, 3'd4, 1'b0, d, f);
    check("R8 load", d, 32'h25);

    // R11: undefined mode
    doRead(100, 2, 3'd7, 1'b1, d, f);
    check("R11 data", d, expArr(100, 2, 1'b1));
    check("R11 flag set", {31'h0, f}, 32'h1);
    doRead(101, 0, 3'd0, 1'b0, d, f);
    check("R11 flag clear", {31'h0, f}, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule